// File: doc/BRIEF.md
# One-wire device identifier CRC-8 checker

This block checks a 64-bit device identifier that has already been captured from a one-wire bus. The identifier is a family code, a serial number and a trailing CRC byte. The capture logic offers the identifier one byte at a time on a valid/ready handshake. A start strobe opens each new identifier.

Each accepted byte is shifted, one bit per clock and least significant bit first, through a bit-serial CRC-8 register with generator x^8 + x^5 + x^4 + 1. The register starts at zero. The CRC byte is absorbed like any other byte. After the eighth byte the block raises a one-cycle done pulse, and the result reads pass when the register is all zero. The result bit holds until the next start.

The block has nothing to do with the bus physical layer, bit timing or device search.

Top module: `onewire_id_crc_check`

## Requirements
- R1: While reset is asserted and in the first cycle after it, ready_o is 1, done_o is 0 and pass_o is 0.
- R2: The register starts at zero and uses generator x^8 + x^5 + x^4 + 1. Per bit, feedback is the incoming bit XOR the register MSB. Feedback enters bit 0 and is XORed into the inputs of bits 4 and 5. Bits of each byte enter LSB first (data_i[0] first). An 8-byte identifier whose eighth byte is the CRC of the first seven gives pass_o = 1, including the all-zero identifier.
- R3: pass_o is 1 only if every register bit is zero after the 64th bit. An identifier with any corrupted bit gives pass_o = 0.
- R4: A byte is accepted in a cycle where valid_i and ready_o are both 1 and sof_i is 0. ready_o is then 0 for exactly the 8 following cycles, one bit being processed per clock, and it returns to 1 in the cycle after that.
- R5: done_o is 1 for exactly one cycle: the cycle after the edge that processes the last bit of the eighth byte.
- R6: pass_o changes only at that done edge or at a start. It holds its value across later cycles and reads 0 in the cycle after sof_i.
- R7: sof_i clears the CRC register, the byte count and any byte being shifted, even mid-frame. A byte offered in the same cycle as sof_i is not accepted, and ready_o is 1 in the following cycle.
- R8: After the eighth byte, and until the next sof_i, ready_o stays 0. Offered bytes are ignored: no done_o pulse follows and pass_o keeps its value.
- R9: A frame may start straight out of reset without a prior sof_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sof_i | input | 1 | Start of a new identifier; clears all frame state |
| valid_i | input | 1 | Byte offered on data_i |
| data_i | input | 8 | Identifier byte, bit 0 processed first |
| ready_o | output | 1 | Block can accept a byte this cycle |
| done_o | output | 1 | One-cycle pulse after the eighth byte |
| pass_o | output | 1 | Result of the last completed identifier (1 = CRC good) |

## Verification
A wrong CRC tap or a wrong bit order stays hidden in the register until the eighth byte completes. It then shows as a wrong pass_o, so every identifier is checked at its done edge. Both good identifiers and identifiers with single-bit corruption are used, so an error shows whichever way the result goes. A wrong bit or byte count shows within one cycle, as a ready_o or done_o edge early or late, because the bench model predicts both every clock. A start that does not clear state shows as a wrong result on the frame after a mid-frame abort.

// File: rtl/idcrc_pkg.sv
package idcrc_pkg;
  // default geometry of a one-wire identifier check
  localparam int unsigned ID_CRC_W  = 8;
  localparam int unsigned ID_BYTE_W = 8;
  localparam int unsigned ID_NBYTES = 8;
  // taps below the x^8 term: x^5 + x^4 + 1
  localparam logic [ID_CRC_W-1:0] ID_POLY = 8'h31;
endpackage

// File: rtl/idcrc_lfsr.sv
module idcrc_lfsr
  import idcrc_pkg::*;
#(
  parameter int unsigned         W    = ID_CRC_W,
  parameter logic [W-1:0]        POLY = ID_POLY
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic en_i,
  input  logic bit_i,
  output logic nxt_zero_o
);

  logic [W-1:0] crc_q;
  logic [W-1:0] crc_d;
  logic [W-1:0] step;
  logic         fb;

  assign fb = bit_i ^ crc_q[W-1];

  // one shift of the Galois register, tap mask taken from POLY
  for (genvar i = 0; i < W; i++) begin : g_tap
    if (i == 0) begin : g_lsb
      assign step[i] = POLY[i] & fb;
    end else begin : g_mid
      assign step[i] = crc_q[i-1] ^ (POLY[i] & fb);
    end
  end

  always_comb begin
    crc_d = crc_q;
    if (clr_i) begin
      crc_d = '0;
    end else if (en_i) begin
      crc_d = step;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      crc_q <= '0;
    end else begin
      crc_q <= crc_d;
    end
  end

  assign nxt_zero_o = (step == '0);

  // R7
  crc_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (crc_q == '0));

endmodule

// File: rtl/idcrc_bitfeed.sv
module idcrc_bitfeed
  import idcrc_pkg::*;
#(
  parameter int unsigned BYTE_W = ID_BYTE_W,
  localparam int unsigned CNT_W = (BYTE_W > 1) ? $clog2(BYTE_W) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              take_i,
  input  logic [BYTE_W-1:0] data_i,
  output logic              busy_o,
  output logic              bit_o,
  output logic              last_o
);

  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(BYTE_W - 1);

  logic [BYTE_W-1:0] sreg_q, sreg_d;
  logic [CNT_W-1:0]  cnt_q,  cnt_d;
  logic              busy_q, busy_d;
  logic              last_bit;

  assign last_bit = busy_q && (cnt_q == LAST_IDX);

  always_comb begin
    sreg_d = sreg_q;
    cnt_d  = cnt_q;
    busy_d = busy_q;
    if (clr_i) begin
      busy_d = 1'b0;
      cnt_d  = '0;
    end else if (busy_q) begin
      sreg_d = sreg_q >> 1;
      cnt_d  = cnt_q + 1'b1;
      if (last_bit) begin
        busy_d = 1'b0;
        cnt_d  = '0;
      end
    end else if (take_i) begin
      sreg_d = data_i;
      cnt_d  = '0;
      busy_d = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sreg_q <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else begin
      sreg_q <= sreg_d;
      cnt_q  <= cnt_d;
      busy_q <= busy_d;
    end
  end

  assign busy_o = busy_q;
  assign bit_o  = sreg_q[0];
  assign last_o = last_bit;

  // R4
  accept_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_i && !clr_i && !busy_q) |=> busy_o);

  // R4
  busy_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (last_o && !clr_i) |=> !busy_o);

endmodule

// File: rtl/idcrc_frame.sv
module idcrc_frame
  import idcrc_pkg::*;
#(
  parameter int unsigned NBYTES = ID_NBYTES,
  localparam int unsigned CNT_W = (NBYTES > 1) ? $clog2(NBYTES) : 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic byte_end_i,
  input  logic crc_zero_i,
  output logic full_o,
  output logic done_o,
  output logic pass_o
);

  localparam logic [CNT_W-1:0] LAST_BYTE = CNT_W'(NBYTES - 1);

  logic [CNT_W-1:0] cnt_q,  cnt_d;
  logic             full_q, full_d;
  logic             done_q, done_d;
  logic             pass_q, pass_d;
  logic             finish;

  assign finish = byte_end_i && (cnt_q == LAST_BYTE) && !full_q;

  always_comb begin
    cnt_d  = cnt_q;
    full_d = full_q;
    pass_d = pass_q;
    done_d = 1'b0;
    if (clr_i) begin
      cnt_d  = '0;
      full_d = 1'b0;
      pass_d = 1'b0;
    end else if (finish) begin
      cnt_d  = '0;
      full_d = 1'b1;
      done_d = 1'b1;
      pass_d = crc_zero_i;
    end else if (byte_end_i) begin
      cnt_d  = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      full_q <= 1'b0;
      done_q <= 1'b0;
      pass_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      full_q <= full_d;
      done_q <= done_d;
      pass_q <= pass_d;
    end
  end

  assign full_o = full_q;
  assign done_o = done_q;
  assign pass_o = pass_q;

  // R5
  done_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R6
  pass_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !finish) |=> $stable(pass_o));

  // R8
  full_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_q && !clr_i) |=> (full_o && !done_o));

endmodule

// File: rtl/onewire_id_crc_check.sv
module onewire_id_crc_check
  import idcrc_pkg::*;
#(
  parameter int unsigned          BYTE_W = ID_BYTE_W,
  parameter int unsigned          NBYTES = ID_NBYTES,
  parameter int unsigned          CRC_W  = ID_CRC_W,
  parameter logic [CRC_W-1:0]     POLY   = ID_POLY
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sof_i,
  input  logic              valid_i,
  input  logic [BYTE_W-1:0] data_i,
  output logic              ready_o,
  output logic              done_o,
  output logic              pass_o
);

  logic busy;
  logic serial_bit;
  logic last_bit;
  logic full;
  logic crc_zero_nxt;
  logic take;

  assign ready_o = !busy && !full;
  assign take    = valid_i && ready_o && !sof_i;

  idcrc_bitfeed #(
    .BYTE_W (BYTE_W)
  ) u_feed (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (sof_i),
    .take_i (take),
    .data_i (data_i),
    .busy_o (busy),
    .bit_o  (serial_bit),
    .last_o (last_bit)
  );

  idcrc_lfsr #(
    .W    (CRC_W),
    .POLY (POLY)
  ) u_lfsr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (sof_i),
    .en_i       (busy),
    .bit_i      (serial_bit),
    .nxt_zero_o (crc_zero_nxt)
  );

  idcrc_frame #(
    .NBYTES (NBYTES)
  ) u_frame (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (sof_i),
    .byte_end_i (last_bit),
    .crc_zero_i (crc_zero_nxt),
    .full_o     (full),
    .done_o     (done_o),
    .pass_o     (pass_o)
  );

  // R7
  sof_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sof_i |=> (ready_o && !done_o && !pass_o));

  // R4
  take_stall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take |=> !ready_o);

endmodule

// File: tb/test_onewire_id_crc_check.sv
module test_onewire_id_crc_check;
  localparam time CLK_PERIOD = 10ns;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sof = 1'b0;
  logic       valid = 1'b0;
  logic [7:0] data = 8'h00;
  logic       ready, done, pass;

  int n_checks = 0;
  int n_fail   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  onewire_id_crc_check i_onewire_id_crc_check (
    .clk_i   (clk),
    .rst_ni  (rst_n),
    .sof_i   (sof),
    .valid_i (valid),
    .data_i  (data),
    .ready_o (ready),
    .done_o  (done),
    .pass_o  (pass)
  );

  // reflected-form reference CRC, byte at a time
  function automatic logic [7:0] ref_crc(input logic [7:0] c, input logic [7:0] b);
    logic [7:0] r;
    r = c ^ b;
    for (int k = 0; k < 8; k++) r = r[0] ? ((r >> 1) ^ 8'h8C) : (r >> 1);
    return r;
  endfunction

  // behavioural cycle model
  int         m_rem;
  int         m_bytes;
  bit         m_full;
  bit         m_done;
  bit         m_pass;
  logic [7:0] m_crc;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_rem = 0; m_bytes = 0; m_full = 0; m_done = 0; m_pass = 0; m_crc = 8'h00;
    end else begin
      m_done = 0;
      if (sof) begin
        m_rem = 0; m_bytes = 0; m_full = 0; m_pass = 0; m_crc = 8'h00;
      end else if (m_rem > 0) begin
        m_rem = m_rem - 1;
        if (m_rem == 0) begin
          m_bytes = m_bytes + 1;
          if (m_bytes == 8) begin
            m_full = 1; m_done = 1; m_pass = (m_crc == 8'h00); m_bytes = 0;
          end
        end
      end else if (valid && !m_full) begin
        m_rem = 8;
        m_crc = ref_crc(m_crc, data);
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      chk(ready == (m_rem == 0 && !m_full), "R4 ready per cycle", ready, (m_rem == 0 && !m_full));
      chk(done == m_done, "R5 done per cycle", done, m_done);
      chk(pass == m_pass, "R6 pass per cycle", pass, m_pass);
    end
  end

  task automatic send_byte(input logic [7:0] b);
    @(negedge clk);
    while (!ready) @(negedge clk);
    valid = 1'b1; data = b;
    @(negedge clk);
    valid = 1'b0;
  endtask

  task automatic pulse_sof();
    @(negedge clk);
    sof = 1'b1;
    @(negedge clk);
    sof = 1'b0;
  endtask

  task automatic make_id(input logic [7:0] seed, ref logic [7:0] id [8]);
    logic [7:0] c;
    c = 8'h00;
    for (int i = 0; i < 7; i++) begin
      id[i] = seed * 8'(i + 3) ^ 8'(i * 37);
      c = ref_crc(c, id[i]);
    end
    id[7] = c;
  endtask

  task automatic run_id(input logic [7:0] id [8], input bit exp_pass, input string tag);
    for (int i = 0; i < 7; i++) send_byte(id[i]);
    send_byte(id[7]);
    // now at the negedge after the accept edge; 7 more edges shift, the 8th finishes
    for (int k = 0; k < 7; k++) begin
      chk(done == 1'b0, "R5 no early done", done, 0);
      @(negedge clk);
    end
    chk(done == 1'b0, "R5 no early done", done, 0);
    @(negedge clk);
    chk(done == 1'b1, "R5 done after last bit", done, 1);
    chk(pass == exp_pass, tag, pass, exp_pass);
    @(negedge clk);
    chk(done == 1'b0, "R5 done one cycle", done, 0);
    chk(pass == exp_pass, "R6 pass held", pass, exp_pass);
  endtask

  initial begin
    logic [7:0] id [8];
    logic [7:0] held;
    int lows;
    repeat (3) @(negedge clk);
    chk(ready == 1'b1 && done == 1'b0 && pass == 1'b0, "R1 reset outputs", {ready, done, pass}, 3'b100);
    rst_n = 1'b1;
    @(negedge clk);
    chk(ready == 1'b1 && done == 1'b0 && pass == 1'b0, "R1 after reset", {ready, done, pass}, 3'b100);

    // R9: first frame without sof; R2: known-good identifier
    make_id(8'h5A, id);
    run_id(id, 1'b1, "R2 R9 good id straight from reset");

    // R8: extra bytes after the eighth are ignored
    held = {7'd0, pass};
    valid = 1'b1; data = 8'hC3;
    for (int k = 0; k < 12; k++) begin
      @(negedge clk);
      chk(ready == 1'b0, "R8 ready low when full", ready, 0);
      chk(done == 1'b0, "R8 no done on extra bytes", done, 0);
      chk(pass == held[0], "R8 pass unchanged", pass, held[0]);
    end
    valid = 1'b0;

    // R6: sof clears pass
    pulse_sof();
    chk(pass == 1'b0, "R6 sof clears pass", pass, 0);
    chk(ready == 1'b1, "R7 ready after sof", ready, 1);

    // R4: ready low exactly 8 cycles
    send_byte(8'h81);
    lows = 0;
    while (!ready && lows < 20) begin lows++; @(negedge clk); end
    chk(lows == 8, "R4 ready low 8 cycles", lows, 8);

    // R7: abort after a partial frame and mid-byte, then a good frame
    send_byte(8'h11); send_byte(8'h22);
    pulse_sof();
    send_byte(8'h7E);
    @(negedge clk); @(negedge clk);
    pulse_sof();
    chk(ready == 1'b1, "R7 sof mid-byte frees ready", ready, 1);
    make_id(8'h13, id);
    run_id(id, 1'b1, "R7 good id after abort");

    // R7: byte offered together with sof is not taken
    @(negedge clk);
    sof = 1'b1; valid = 1'b1; data = 8'hFF;
    @(negedge clk);
    sof = 1'b0; valid = 1'b0;
    chk(ready == 1'b1, "R7 byte with sof not accepted", ready, 1);

    // R3: corrupted payload bit and corrupted CRC bit
    make_id(8'hA7, id);
    id[3] = id[3] ^ 8'h04;
    run_id(id, 1'b0, "R3 flipped payload bit fails");
    pulse_sof();
    make_id(8'h3C, id);
    id[7] = id[7] ^ 8'h80;
    run_id(id, 1'b0, "R3 flipped crc bit fails");
    pulse_sof();
    make_id(8'h3C, id);
    id[0] = id[0] ^ 8'h01;
    run_id(id, 1'b0, "R3 flipped first bit fails");

    // R2: boundary identifiers
    pulse_sof();
    for (int i = 0; i < 8; i++) id[i] = 8'h00;
    run_id(id, 1'b1, "R2 all-zero id passes");
    pulse_sof();
    begin
      logic [7:0] c;
      c = 8'h00;
      for (int i = 0; i < 7; i++) begin id[i] = 8'hFF; c = ref_crc(c, 8'hFF); end
      id[7] = c;
    end
    run_id(id, 1'b1, "R2 all-ones payload passes");
    pulse_sof();
    make_id(8'hE1, id);
    run_id(id, 1'b1, "R2 good id passes");

    repeat (3) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    n_fail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule